// File: doc/BRIEF.md
# Bus-Triggered 32-by-16 Unsigned Divide Unit

This unit sits on the data bus of a small processor and performs unsigned division of a 32-bit value by a 16-bit value. Software fills three 16-bit operand registers: the upper dividend half, the lower dividend half and the divisor. It then writes a command word to a fixed trigger address. A fixed-length sequence follows. At its end the quotient has replaced the lower dividend half and the remainder has replaced the upper dividend half. Four condition flags (overflow, negative, carry, zero) are presented to the processor.

The datapath is a restoring shift-subtract divider that produces one quotient bit per clock. A controller steps it through seven states. ST_IDLE waits for a trigger and moves to ST_LOAD when an accepted command arrives. ST_LOAD copies the operands into the datapath and always moves to ST_CHECK. ST_CHECK flags overflow (divisor zero, or upper half not below the divisor) and always moves to ST_ITER. ST_ITER stays for 16 cycles, one per quotient bit, and then moves to ST_ALIGN. ST_ALIGN is a pad cycle that always moves to ST_WRITE. ST_WRITE commits results and flags and always moves to ST_FIN. ST_FIN signals completion and always returns to ST_IDLE. From trigger to completion the sequence takes 21 cycles, whatever the operands.

Top module: `wdiv_unit`

## Requirements
- R1: While idle, a bus write stores `bus_wdata` into the upper dividend register at address 0x03F02, the lower dividend register at 0x03F03, or the divisor register at 0x03F04. Each register is visible on its output port from the next cycle.
- R2: While idle, a bus write of the full 16-bit word 0x0004 to address 0x03F07 starts a divide. Any other word written to 0x03F07 starts nothing and changes no register.
- R3: When the divide does not overflow, completion replaces the lower dividend register with the quotient floor({hi,lo}/divisor) and the upper dividend register with the remainder.
- R4: `flag_v` is 1 after completion exactly when the divisor is zero or the upper dividend is greater than or equal to the divisor. In that case both dividend registers keep their values.
- R5: `flag_c` is 0 after every completion.
- R6: When `flag_v` is 0 after completion, `flag_n` equals bit 15 of the quotient.
- R7: When `flag_v` is 0 after completion, `flag_z` is 1 if the quotient is zero and 0 otherwise.
- R8: `busy` is high for exactly 21 consecutive cycles. The first of these is the cycle after the edge that accepts the trigger.
- R9: `done` is high only in the 21st busy cycle, for one cycle. Results and flags are already on the ports in that cycle.
- R10: Bus writes to any operand register or to the trigger address while `busy` is high are ignored. This includes a write in the `done` cycle.
- R11: After reset, all three operand registers and all four flags read 0, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 18 | Bus write address |
| bus_wdata | input | 16 | Bus write data |
| dvd_hi | output | 16 | Upper dividend / remainder register |
| dvd_lo | output | 16 | Lower dividend / quotient register |
| divisor | output | 16 | Divisor register |
| busy | output | 1 | Divide sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_v | output | 1 | Quotient overflow flag |
| flag_n | output | 1 | Quotient sign-bit flag |
| flag_c | output | 1 | Carry flag (cleared by a divide) |
| flag_z | output | 1 | Quotient zero flag |

## Verification
The writeback of quotient and remainder competes with a bus write to the same operand registers. In the `done` cycle the results are fresh while a write could still land, and the very next cycle is the first in which a write is legal again. The bench aims writes at the lower dividend register exactly in the `done` cycle and again in the following idle cycle. It also aims writes and a second trigger into the middle of the window. A behavioural reference model compares every clock and requires the first write to vanish and the second to take effect.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_ITER,
        ST_ALIGN,
        ST_WRITE,
        ST_FIN
    } wdiv_state_e;

    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } wdiv_flags_t;

endpackage

// File: rtl/wdiv_ctrl.sv
module wdiv_ctrl
    import wdiv_pkg::*;
#(
    parameter int ITERS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic check,
    output logic step,
    output logic wb,
    output logic done
);

    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    wdiv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_ITER) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_CHECK;
            ST_CHECK: state_d = ST_ITER;
            ST_ITER:  if (cnt_q == LAST) state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_WRITE;
            ST_WRITE: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = 1'b1;
        load  = 1'b0;
        check = 1'b0;
        step  = 1'b0;
        wb    = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy  = 1'b0;
            ST_LOAD:  load  = 1'b1;
            ST_CHECK: check = 1'b1;
            ST_ITER:  step  = 1'b1;
            ST_ALIGN: ;
            ST_WRITE: wb    = 1'b1;
            ST_FIN:   done  = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    // R8: iterations occupy exactly ITERS cycles, counted from the check cycle
    a_r8_iter_follows_check: assert property (@(posedge clk) disable iff (!rst_n)
        check |=> step);
    a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wb |=> done);

endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          check,
    input  logic          step,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] dvsr_i,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem,
    output logic          ovf
);

    logic [DW-1:0] rem_q, quo_q, dvsr_q;
    logic          ovf_q;
    logic [DW:0]   trial;
    logic [DW-1:0] diff;
    logic          fits;

    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        fits  = (trial >= {1'b0, dvsr_q});
        diff  = trial[DW-1:0] - dvsr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
            ovf_q  <= 1'b0;
        end else if (load) begin
            rem_q  <= hi_i;
            quo_q  <= lo_i;
            dvsr_q <= dvsr_i;
            ovf_q  <= 1'b0;
        end else if (check) begin
            ovf_q  <= (dvsr_q == '0) || (rem_q >= dvsr_q);
        end else if (step) begin
            rem_q  <= fits ? diff : trial[DW-1:0];
            quo_q  <= {quo_q[DW-2:0], fits};
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;
    assign ovf = ovf_q;

    // R4: a zero divisor is always reported as overflow
    a_r4_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (check && dvsr_q == '0) |=> ovf_q);
    // R3: restoring step keeps the partial remainder below the divisor
    a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ovf_q) |=> (rem_q < dvsr_q));

endmodule

// File: rtl/wdiv_regs.sv
module wdiv_regs
    import wdiv_pkg::*;
#(
    parameter int              AW        = 18,
    parameter int              DW        = 16,
    parameter logic [AW-1:0]   ADDR_HI   = 18'h03F02,
    parameter logic [AW-1:0]   ADDR_LO   = 18'h03F03,
    parameter logic [AW-1:0]   ADDR_DV   = 18'h03F04,
    parameter logic [AW-1:0]   ADDR_TRIG = 18'h03F07,
    parameter logic [DW-1:0]   CMD_DIV   = 16'h0004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          busy,
    input  logic          wb,
    input  logic          ovf,
    input  logic [DW-1:0] quo,
    input  logic [DW-1:0] rem,
    output logic [DW-1:0] hi,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] dvsr,
    output wdiv_flags_t   flags,
    output logic          start
);

    logic wr_ok;

    assign wr_ok = bus_we && !busy;
    assign start = wr_ok && (bus_addr == ADDR_TRIG) && (bus_wdata == CMD_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi    <= '0;
            lo    <= '0;
            dvsr  <= '0;
            flags <= '0;
        end else if (wb) begin
            if (!ovf) begin
                hi <= rem;
                lo <= quo;
            end
            flags.v <= ovf;
            flags.c <= 1'b0;
            flags.n <= !ovf && quo[DW-1];
            flags.z <= !ovf && (quo == '0);
        end else if (wr_ok) begin
            if (bus_addr == ADDR_HI) hi   <= bus_wdata;
            if (bus_addr == ADDR_LO) lo   <= bus_wdata;
            if (bus_addr == ADDR_DV) dvsr <= bus_wdata;
        end
    end

    // R10: operand registers frozen while busy, except the writeback edge
    a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb) |=> ($stable(hi) && $stable(lo) && $stable(dvsr)));
    // R4: overflow leaves the dividend untouched
    a_r4_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wb && ovf) |=> ($stable(hi) && $stable(lo)));

endmodule

// File: rtl/wdiv_unit.sv
module wdiv_unit
    import wdiv_pkg::*;
#(
    parameter int              ADDR_W    = 18,
    parameter int              DATA_W    = 16,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 18'h03F02,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 18'h03F03,
    parameter logic [ADDR_W-1:0] ADDR_DV   = 18'h03F04,
    parameter logic [ADDR_W-1:0] ADDR_TRIG = 18'h03F07,
    parameter logic [DATA_W-1:0] CMD_DIV   = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] dvd_hi,
    output logic [DATA_W-1:0] dvd_lo,
    output logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic              flag_v,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_z
);

    localparam int ITERS  = DATA_W;
    localparam int WINDOW = ITERS + 5;
    localparam int WCW    = $clog2(WINDOW + 1);

    logic              start, load, check, step, wb, ovf;
    logic [DATA_W-1:0] quo, rem;
    wdiv_flags_t       flags;

    wdiv_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .check (check),
        .step  (step),
        .wb    (wb),
        .done  (done)
    );

    wdiv_core #(.DW(DATA_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .check  (check),
        .step   (step),
        .hi_i   (dvd_hi),
        .lo_i   (dvd_lo),
        .dvsr_i (divisor),
        .quo    (quo),
        .rem    (rem),
        .ovf    (ovf)
    );

    wdiv_regs #(
        .AW        (ADDR_W),
        .DW        (DATA_W),
        .ADDR_HI   (ADDR_HI),
        .ADDR_LO   (ADDR_LO),
        .ADDR_DV   (ADDR_DV),
        .ADDR_TRIG (ADDR_TRIG),
        .CMD_DIV   (CMD_DIV)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .wb        (wb),
        .ovf       (ovf),
        .quo       (quo),
        .rem       (rem),
        .hi        (dvd_hi),
        .lo        (dvd_lo),
        .dvsr      (divisor),
        .flags     (flags),
        .start     (start)
    );

    assign flag_v = flags.v;
    assign flag_n = flags.n;
    assign flag_c = flags.c;
    assign flag_z = flags.z;

    // busy-window length tracker for the window assertions
    logic [WCW-1:0] win_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (busy) begin
            win_q <= win_q + 1'b1;
        end else begin
            win_q <= '0;
        end
    end

    // R9: done lands in the last cycle of the window
    a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (win_q == WCW'(WINDOW - 1)));
    // R8: busy never outlasts the window and drops after done
    a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (win_q < WCW'(WINDOW)));
    a_r8_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R2: the window only opens on an accepted trigger
    a_r2_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R6: sign flag tracks quotient MSB when no overflow
    a_r6_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_v) |-> (flag_n == dvd_lo[DATA_W-1]));

endmodule

// File: tb/wdiv_unit_bench.sv
`timescale 1ns/1ps
module wdiv_unit_bench;

    localparam logic [17:0] A_HI   = 18'h03F02;
    localparam logic [17:0] A_LO   = 18'h03F03;
    localparam logic [17:0] A_DV   = 18'h03F04;
    localparam logic [17:0] A_TRIG = 18'h03F07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] dvd_hi, dvd_lo, divisor;
    logic        busy, done, flag_v, flag_n, flag_c, flag_z;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wdiv_unit u_wdiv_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
        .divisor(divisor), .busy(busy), .done(done), .flag_v(flag_v),
        .flag_n(flag_n), .flag_c(flag_c), .flag_z(flag_z)
    );

    // ---------------- reference model ----------------
    int unsigned m_hi, m_lo, m_dv;
    bit m_v, m_n, m_c, m_z;
    int phase;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_dv = 0;
            m_v = 0; m_n = 0; m_c = 0; m_z = 0;
            phase = 0;
        end else if (phase == 0) begin
            if (bus_we) begin
                if (bus_addr == A_HI) m_hi = bus_wdata;
                else if (bus_addr == A_LO) m_lo = bus_wdata;
                else if (bus_addr == A_DV) m_dv = bus_wdata;
                else if (bus_addr == A_TRIG && bus_wdata == 16'h0004) phase = 1;
            end
        end else if (phase == 20) begin
            longint unsigned num, q;
            num = (longint'(m_hi) << 16) | m_lo;
            m_c = 0;
            if (m_dv == 0 || num / m_dv > 64'hFFFF) begin
                m_v = 1;
            end else begin
                q = num / m_dv;
                m_hi = int'(num % m_dv);
                m_lo = int'(q);
                m_v = 0;
                m_n = q[15];
                m_z = (q == 0);
            end
            phase = 21;
        end else if (phase == 21) begin
            phase = 0;
        end else begin
            phase = phase + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            chk("R8 busy", {31'd0, busy}, {31'd0, phase != 0});
            chk("R9 done", {31'd0, done}, {31'd0, phase == 21});
            chk("R3 dvd_hi", {16'd0, dvd_hi}, m_hi);
            chk("R3 dvd_lo", {16'd0, dvd_lo}, m_lo);
            chk("R1 divisor", {16'd0, divisor}, m_dv);
            chk("R4 flag_v", {31'd0, flag_v}, {31'd0, m_v});
            chk("R5 flag_c", {31'd0, flag_c}, {31'd0, m_c});
            if (!m_v) begin
                chk("R6 flag_n", {31'd0, flag_n}, {31'd0, m_n});
                chk("R7 flag_z", {31'd0, flag_z}, {31'd0, m_z});
            end
        end
    end

    // ---------------- stimulus ----------------
    // drives now (just after a falling edge), holds through one rising edge
    task automatic bus_write(input logic [17:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_div(input logic [15:0] h, input logic [15:0] l, input logic [15:0] d,
                           input logic [15:0] eh, input logic [15:0] el, input bit ev,
                           input bit en, input bit ez, input string tag);
        bus_write(A_HI, h);
        bus_write(A_LO, l);
        bus_write(A_DV, d);
        bus_write(A_TRIG, 16'h0004);
        idle_cycles(20);
        chk({tag, " R9 done in 21st cycle"}, {31'd0, done}, 32'd1);
        chk({tag, " R3 quotient/lo"}, {16'd0, dvd_lo}, {16'd0, el});
        chk({tag, " R3 remainder/hi"}, {16'd0, dvd_hi}, {16'd0, eh});
        chk({tag, " R4 overflow"}, {31'd0, flag_v}, {31'd0, ev});
        chk({tag, " R5 carry"}, {31'd0, flag_c}, 32'd0);
        if (!ev) begin
            chk({tag, " R6 sign"}, {31'd0, flag_n}, {31'd0, en});
            chk({tag, " R7 zero"}, {31'd0, flag_z}, {31'd0, ez});
        end
        idle_cycles(1);
        chk({tag, " R8 busy dropped"}, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(1);
        // R11: reset state
        chk("R11 reset regs", {dvd_hi, dvd_lo}, 32'd0);
        chk("R11 reset divisor", {16'd0, divisor}, 32'd0);
        chk("R11 reset flags/busy/done",
            {26'd0, flag_v, flag_n, flag_c, flag_z, busy, done}, 32'd0);
        chk_en = 1'b1;

        // R1: plain register writes
        bus_write(A_HI, 16'hA5A5);
        bus_write(A_LO, 16'h5A5A);
        bus_write(A_DV, 16'h1234);
        chk("R1 write hi", {16'd0, dvd_hi}, 32'h0000A5A5);
        chk("R1 write lo", {16'd0, dvd_lo}, 32'h00005A5A);
        chk("R1 write divisor", {16'd0, divisor}, 32'h00001234);

        // R2: wrong command codes start nothing
        bus_write(A_TRIG, 16'h0005);
        chk("R2 code 0x0005 ignored", {31'd0, busy}, 32'd0);
        bus_write(A_TRIG, 16'h0104);
        chk("R2 code 0x0104 ignored", {31'd0, busy}, 32'd0);
        chk("R2 regs untouched", {dvd_hi, dvd_lo}, 32'hA5A55A5A);

        run_div(16'h0001, 16'h2345, 16'h0100, 16'h0045, 16'h0123, 0, 0, 0, "basic");
        run_div(16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFE, 16'hFFFF, 0, 1, 0, "max");
        run_div(16'h0000, 16'h0005, 16'h0007, 16'h0005, 16'h0000, 0, 0, 1, "zeroq");
        run_div(16'h8000, 16'h0000, 16'hFFFF, 16'h8000, 16'h8000, 0, 1, 0, "msb");
        run_div(16'h0007, 16'h0000, 16'h0007, 16'h0007, 16'h0000, 1, 0, 0, "hi_eq_dv");
        run_div(16'h0000, 16'h0010, 16'h0000, 16'h0000, 16'h0010, 1, 0, 0, "div0");
        run_div(16'h0003, 16'hFFFF, 16'h0004, 16'h0003, 16'hFFFF, 0, 1, 0, "near");

        // R10: writes and re-trigger during the window, plus done-cycle collision
        bus_write(A_HI, 16'h0000);
        bus_write(A_LO, 16'h0064);
        bus_write(A_DV, 16'h000A);
        bus_write(A_TRIG, 16'h0004);       // now in busy cycle 1
        idle_cycles(4);                     // busy cycle 5
        bus_write(A_HI, 16'h7777);
        idle_cycles(3);                     // busy cycle 9
        bus_write(A_TRIG, 16'h0004);
        chk("R10 divisor write ignored pre", {16'd0, divisor}, 32'h0000000A);
        idle_cycles(10);                    // busy cycle 20
        bus_write(A_DV, 16'h0099);
        // now in the done cycle
        chk("R9 done cycle reached", {31'd0, done}, 32'd1);
        chk("R3 result 100/10", {dvd_hi, dvd_lo}, 32'h0000000A);
        bus_write(A_LO, 16'hBEEF);          // lands in done cycle: dropped
        chk("R10 done-cycle write dropped", {16'd0, dvd_lo}, 32'h0000000A);
        chk("R10 divisor unchanged", {16'd0, divisor}, 32'h0000000A);
        chk("R10 no retrigger", {31'd0, busy}, 32'd0);
        bus_write(A_LO, 16'hCAFE);          // first idle cycle: accepted
        chk("R1 write after window", {16'd0, dvd_lo}, 32'h0000CAFE);

        // randomized divides, some with busy-time traffic
        for (int i = 0; i < 60; i++) begin
            logic [15:0] rh, rl, rd;
            rd = 16'($urandom_range(0, 65535));
            rh = (i % 4 == 0) ? 16'($urandom) : 16'($urandom_range(0, 65535) % (rd == 0 ? 1 : rd));
            rl = 16'($urandom);
            bus_write(A_HI, rh);
            bus_write(A_LO, rl);
            bus_write(A_DV, rd);
            bus_write(A_TRIG, 16'h0004);
            idle_cycles(int'($urandom_range(0, 18)));
            bus_write((i % 2 == 0) ? A_LO : A_TRIG, 16'h0004);
            idle_cycles(22);
        end

        chk_en = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule